// File: doc/BRIEF.md
# Three-Moduli Forward Residue Converter

This block takes an unsigned binary word and returns its residues with respect to the moduli 2^N−1, 2^N and 2^N+1, where N is a parameter. The input is first zero-extended to 3N bits and cut into three N-bit slices. The slices are named top, middle and low, with the low slice holding bits N−1..0.

No divider is involved.
- **Modulus 2^N:** the residue is the low slice unchanged.
- **Modulus 2^N−1:** the middle and low slices are summed in a modular adder, and a second adder then adds the top slice.
- **Modulus 2^N+1:** the low slice is added to the modular negation of the middle slice, and a second adder then adds the top slice.

Every adder returns a+b when that sum is below m, and a+b−m otherwise.

An optional output stage registers the three residues together with a valid flag. Two typical configurations are a 5-bit exponent on N=2, giving moduli 3, 4 and 5, and a 10-bit mantissa on N=8, giving moduli 255, 256 and 257.

Top module: `rns3_fwd`

## Requirements
- R1: `res_m` equals the input modulo 2^N, which is bits N−1..0 of the zero-extended input.
- R2: `res_m1` equals the input modulo 2^N−1, for every input value.
- R3: `res_m1` never shows the all-ones value 2^N−1. A value congruent to zero is reported as 0.
- R4: `res_p1` is N+1 bits wide and equals the input modulo 2^N+1, so it always lies in 0..2^N.
- R5: When IN_W is smaller than 3N, the missing upper bits are taken as zero. The residues are then those of the unsigned value of `x_in`.
- R6: With REG_OUT=1, the residues and `out_valid` are captured on the rising clock edge. They hold their values until the next edge, so `out_valid` follows `in_valid` one cycle later.
- R7: With REG_OUT=1, while `rst_n` is low, `out_valid` is 0 and all three residues are 0.
- R8: With REG_OUT=0, the residues are combinational functions of `x_in`, and `out_valid` equals `in_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `x_in` as carrying a value to convert |
| x_in | input | IN_W | Unsigned binary input, IN_W ≤ 3N |
| out_valid | output | 1 | Marks the residue outputs as valid |
| res_m1 | output | N | Residue modulo 2^N−1 |
| res_m | output | N | Residue modulo 2^N |
| res_p1 | output | N+1 | Residue modulo 2^N+1 |

## Verification
The hardest cases to reach are slices that equal 2^N−1. In the 2^N−1 channel, such a slice must be folded to zero before it enters an adder, or the result lands on the forbidden all-ones code. The hardest case in the 2^N+1 channel is a zero middle slice, whose negation must stay at zero rather than become 2^N+1. Random 24-bit words almost never produce an all-ones slice. The bench therefore sweeps every input exhaustively for N=2 (5-bit input) and N=4, and every 10-bit input for N=8. Directed words with all-ones and zero slices are placed ahead of the random 24-bit stream.

// File: rtl/rns3_fwd.sv
module rns3_fwd #(
  parameter int N       = 4,
  parameter int IN_W    = 3 * N,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] x_in,
  output logic            out_valid,
  output logic [N-1:0]    res_m1,
  output logic [N-1:0]    res_m,
  output logic [N:0]      res_p1
);
  localparam int         XW     = 3 * N;
  localparam logic [N:0] MOD_LO = {1'b0, {N{1'b1}}};
  localparam logic [N+1:0] MOD_HI = {2'b01, {(N-1){1'b0}}, 1'b1};

  function automatic logic [N-1:0] add_lo(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= MOD_LO) s = s - MOD_LO;
    return s[N-1:0];
  endfunction

  function automatic logic [N:0] add_hi(input logic [N:0] a, input logic [N:0] b);
    logic [N+1:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= MOD_HI) s = s - MOD_HI;
    return s[N:0];
  endfunction

  logic [XW-1:0] xe;
  logic [N-1:0]  blk_t, blk_m, blk_l;
  logic [N-1:0]  fld_t, fld_m, fld_l;
  logic [N:0]    neg_m;
  logic [N-1:0]  c_m1;
  logic [N:0]    c_p1;

  assign xe    = XW'(x_in);
  assign blk_t = xe[3*N-1:2*N];
  assign blk_m = xe[2*N-1:N];
  assign blk_l = xe[N-1:0];

  assign fld_t = (blk_t == {N{1'b1}}) ? '0 : blk_t;
  assign fld_m = (blk_m == {N{1'b1}}) ? '0 : blk_m;
  assign fld_l = (blk_l == {N{1'b1}}) ? '0 : blk_l;

  assign neg_m = (blk_m == '0) ? '0 : (MOD_HI[N:0] - {1'b0, blk_m});

  assign c_m1 = add_lo(add_lo(fld_m, fld_l), fld_t);
  assign c_p1 = add_hi(add_hi({1'b0, blk_l}, neg_m), {1'b0, blk_t});

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          res_m1    <= '0;
          res_m     <= '0;
          res_p1    <= '0;
        end else begin
          out_valid <= in_valid;
          res_m1    <= c_m1;
          res_m     <= blk_l;
          res_p1    <= c_p1;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign res_m1    = c_m1;
      assign res_m     = blk_l;
      assign res_p1    = c_p1;
    end
  endgenerate
endmodule

// File: rtl/rns3_fwd_chk.sv
module rns3_fwd_chk #(
  parameter int N       = 4,
  parameter int IN_W    = 3 * N,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [IN_W-1:0] x_in,
  input logic            out_valid,
  input logic [N-1:0]    res_m1,
  input logic [N-1:0]    res_m,
  input logic [N:0]      res_p1
);
  localparam logic [N:0] TOP_P1 = {1'b1, {N{1'b0}}};

  logic [3*N-1:0] xe;
  logic           started;

  assign xe = (3*N)'(x_in);

  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r3_no_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    res_m1 != {N{1'b1}});

  a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_p1 <= TOP_P1);

  generate
    if (REG_OUT) begin : g_reg
      a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> out_valid == $past(in_valid));
      a_r1_low_block: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> res_m == $past(xe[N-1:0]));
    end else begin : g_comb
      a_r8_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      a_r1_low_block: assert property (@(posedge clk) disable iff (!rst_n)
        res_m == xe[N-1:0]);
    end
  endgenerate
endmodule

bind rns3_fwd rns3_fwd_chk #(.N(N), .IN_W(IN_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
  .out_valid(out_valid), .res_m1(res_m1), .res_m(res_m), .res_p1(res_p1)
);

// File: tb/rns3_fwd_test.sv
module rns3_fwd_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  always #5 clk = ~clk;

  logic [11:0] x4 = '0;
  logic [4:0]  x2 = '0;
  logic [23:0] x8 = '0;
  logic [9:0]  x8m = '0;

  logic ov4, ov2, ov8, ov8m;
  logic [3:0] a4, b4; logic [4:0] c4;
  logic [1:0] a2, b2; logic [2:0] c2;
  logic [7:0] a8, b8; logic [8:0] c8;
  logic [7:0] a8m, b8m; logic [8:0] c8m;

  rns3_fwd #(.N(4), .IN_W(12), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .x_in(x4),
    .out_valid(ov4), .res_m1(a4), .res_m(b4), .res_p1(c4));
  rns3_fwd #(.N(2), .IN_W(5), .REG_OUT(1'b0)) uut_n2 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .x_in(x2),
    .out_valid(ov2), .res_m1(a2), .res_m(b2), .res_p1(c2));
  rns3_fwd #(.N(8), .IN_W(24), .REG_OUT(1'b1)) uut_n8 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .x_in(x8),
    .out_valid(ov8), .res_m1(a8), .res_m(b8), .res_p1(c8));
  rns3_fwd #(.N(8), .IN_W(10), .REG_OUT(1'b0)) uut_n8m (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .x_in(x8m),
    .out_valid(ov8m), .res_m1(a8m), .res_m(b8m), .res_p1(c8m));

  int checks = 0;
  int fails = 0;
  longint p4 [4];
  longint p8 [4];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint md(input longint v, input longint m);
    return v % m;
  endfunction

  task automatic step(input logic v, input logic [11:0] n4, input logic [4:0] n2,
                      input logic [23:0] n8, input logic [9:0] n8m);
    @(negedge clk);
    vld = v; x4 = n4; x2 = n2; x8 = n8; x8m = n8m;
    #1;
    // R6: registered outputs must still hold the previous capture
    chk("R6 hold valid n4", ov4, p4[0]);
    chk("R6 hold m1 n4", a4, p4[1]);
    chk("R6 hold p1 n4", c4, p4[3]);
    chk("R6 hold m1 n8", a8, p8[1]);
    chk("R6 hold p1 n8", c8, p8[3]);
    @(posedge clk);
    #1;
    chk("R6 valid n4", ov4, v);
    chk("R1 n4", b4, md(n4, 16));
    chk("R2 n4", a4, md(n4, 15));
    chk("R3 n4", a4 == 4'hF, 0);
    chk("R4 n4", c4, md(n4, 17));
    chk("R8 valid n2", ov2, v);
    chk("R5 R1 n2", b2, md(n2, 4));
    chk("R5 R2 n2", a2, md(n2, 3));
    chk("R5 R4 n2", c2, md(n2, 5));
    chk("R1 n8", b8, md(n8, 256));
    chk("R2 n8", a8, md(n8, 255));
    chk("R3 n8", a8 == 8'hFF, 0);
    chk("R4 n8", c8, md(n8, 257));
    chk("R8 valid n8m", ov8m, v);
    chk("R5 R2 n8m", a8m, md(n8m, 255));
    chk("R5 R4 n8m", c8m, md(n8m, 257));
    chk("R5 R1 n8m", b8m, md(n8m, 256));
    p4[0] = v; p4[1] = md(n4, 15); p4[2] = md(n4, 16); p4[3] = md(n4, 17);
    p8[0] = v; p8[1] = md(n8, 255); p8[2] = md(n8, 256); p8[3] = md(n8, 257);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] dir [8];
    dir[0] = 24'h000000; dir[1] = 24'hFFFFFF; dir[2] = 24'hFF00FF;
    dir[3] = 24'h00FF00; dir[4] = 24'hFFFF00; dir[5] = 24'h0000FF;
    dir[6] = 24'h010001; dir[7] = 24'hFEFF01;
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) begin p4[k] = 0; p8[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset valid", ov4, 0);
    chk("R7 reset m1", a4, 0);
    chk("R7 reset m", b4, 0);
    chk("R7 reset p1", c4, 0);
    chk("R7 reset n8 valid", ov8, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    p4[0] = vld; p4[1] = 0; p4[2] = 0; p4[3] = 0;
    p8[0] = vld; p8[1] = 0; p8[2] = 0; p8[3] = 0;
    for (int i = 0; i < 4096; i++) begin
      logic [23:0] r8;
      r8 = (i < 8) ? dir[i] : 24'($urandom);
      step(i[0] ^ i[3], 12'(i), i[4:0], r8, i[9:0]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule